// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

This block gathers 32 interrupt lines into a single request for a processor. It watches each line for changes and keeps one latched bit per line: a rising change sets the bit and a falling change clears it. An enable bit per line decides whether a latched line counts as pending. The block drives a normal interrupt request whenever any enabled line is latched high. A fast interrupt request comes from a second mask that is fixed when the block is built.

Software reaches the block through a small read/write register port. It turns lines on and off one at a time by writing the line's index, not a bit pattern. It can drop every latched level with a single write, and this write leaves the enables as they were. Two read registers give the number of pending lines and the index of the lowest pending line. The count is kept up to date on every clock, so the handler can read how much work is waiting without scanning.

Top module: `level_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the level vector, the enable mask and the pending count are zero, and `irq_o` and `fiq_o` are low.
- R2: A line's latched level goes to 1 on a clock where `irq_in` for that line is 1 and was 0 on the previous clock. It goes to 0 on a falling change. A line that holds its value leaves its latched bit unchanged.
- R3: A write to offset 0x10 with an index below 32 sets that line's enable bit. Enabling a line that is already enabled changes nothing.
- R4: A write to offset 0x0C with an index below 32 clears that line's enable bit. Disabling a line that is already disabled changes nothing.
- R5: A read of offset 0x00 returns the number of lines that are both latched high and enabled. This holds every cycle, including cycles where input changes and a write happen together.
- R6: A read of offset 0x04 returns the lowest index that is both latched high and enabled, or 0 when no line qualifies.
- R7: A write to offset 0x08 clears every latched level and sets the count to 0, and the enables are kept. It overrides any input change in the same cycle. A line that is held high through this write stays unlatched until it falls and rises again.
- R8: `irq_o` is registered. One clock after a change, it equals the OR of (latched level AND enable).
- R9: `fiq_o` is registered. It equals the OR of (latched level AND the `FAST_MASK` parameter), and it stays low when the parameter is zero.
- R10: A read of any other offset returns 0, and so does any access with `bus_rd` low. A write to another offset, or an enable or disable write whose data is 32 or more, leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | 32 | Interrupt source lines |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; when low, read data is 0 |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data: the line index for enable and disable |
| bus_rdata | output | 32 | Read data, combinational from the offset and the current state |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach is a clear-all write that lands on the same clock as a rising input on an enabled line. A later fall and rise on a line held through the clear also has to be driven to show that it latches again. The bench sets up this collision on purpose and then toggles the surviving line by hand. A long random phase follows. It mixes input toggles with enable, disable, clear-all, out-of-range and unmapped writes on the same clocks, so the count is tested against many adds and removals at once.

// File: rtl/pic_pkg.sv
// Package: shared register offsets and access decode for the interrupt aggregator.
// Assumes a 12-bit byte offset on the register port.
package pic_pkg;
    localparam int unsigned ADDR_W = 12;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_COUNT,
        ACC_LINE,
        ACC_CLRALL,
        ACC_DIS,
        ACC_EN
    } acc_e;

    // Map a byte offset onto the register it selects.
    function automatic acc_e decode_ofs(input logic [ADDR_W-1:0] ofs);
        case (ofs)
            12'h000: decode_ofs = ACC_COUNT;
            12'h004: decode_ofs = ACC_LINE;
            12'h008: decode_ofs = ACC_CLRALL;
            12'h00C: decode_ofs = ACC_DIS;
            12'h010: decode_ofs = ACC_EN;
            default: decode_ofs = ACC_NONE;
        endcase
    endfunction
endpackage

// File: rtl/pic_level_latch.sv
// Module: per-line change detector and latched level vector.
// Sets a bit on a rising change and clears it on a falling change.
// A clear request overrides both. Assumes synchronous active-low reset.
module pic_level_latch #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_in,
    input  logic         clear_all,
    output logic [N-1:0] level_o,
    output logic [N-1:0] level_nx_o
);
    logic [N-1:0] in_q;
    logic [N-1:0] lvl_q;
    logic [N-1:0] lvl_nx;

    // Hold the previous sample of each line for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= line_in;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        // Next latched value of one line.
        always_comb begin
            if (clear_all)                   lvl_nx[i] = 1'b0;
            else if (line_in[i] && !in_q[i]) lvl_nx[i] = 1'b1;
            else if (!line_in[i] && in_q[i]) lvl_nx[i] = 1'b0;
            else                             lvl_nx[i] = lvl_q[i];
        end
    end

    // Register the latched level vector.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_nx;
    end

    assign level_o    = lvl_q;
    assign level_nx_o = lvl_nx;

    p_steady_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_all && line_in == in_q) |=> $stable(lvl_q));
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (lvl_q == '0));
endmodule

// File: rtl/pic_enable_regs.sv
// Module: per-line enable mask, changed one line at a time by index.
// Assumes the caller has already range-checked the index and qualified
// the set and clear strobes, which are never both high.
module pic_enable_regs #(
    parameter int unsigned N     = 32,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] idx,
    output logic [N-1:0]     en_o,
    output logic [N-1:0]     en_nx_o
);
    logic [N-1:0] en_q;
    logic [N-1:0] en_nx;
    logic [N-1:0] sel;

    // Turn the index into a one-hot select and apply it.
    always_comb begin
        sel   = '0;
        sel[idx] = 1'b1;
        en_nx = en_q;
        if (set_en)      en_nx = en_q | sel;
        else if (clr_en) en_nx = en_q & ~sel;
    end

    // Register the enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_nx;
    end

    assign en_o    = en_q;
    assign en_nx_o = en_nx;

    p_enable_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> en_q[$past(idx)]);
    p_disable_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !en_q[$past(idx)]);
    p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(en_q));
endmodule

// File: rtl/pic_lowest.sv
// Module: finds the lowest set bit of a vector; returns 0 when it is empty.
// Purely combinational.
module pic_lowest #(
    parameter int unsigned N     = 32,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from the top so that the lowest set bit is the last one kept.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/level_irq_ctrl.sv
// Module: top of the interrupt aggregator. It decodes the register port,
// keeps a running count of pending lines, and registers both request outputs.
// Assumes N >= 2 and a 32-bit data bus. Reset is synchronous and active low.
module level_irq_ctrl
    import pic_pkg::*;
#(
    parameter int unsigned N         = 32,
    parameter logic [31:0] FAST_MASK = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       irq_in,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam int unsigned IDX_W = $clog2(N);
    localparam int unsigned CNT_W = $clog2(N + 1);

    acc_e             acc;
    logic             idx_ok;
    logic             clear_all;
    logic             set_en;
    logic             clr_en;
    logic [N-1:0]     level_q;
    logic [N-1:0]     level_nx;
    logic [N-1:0]     en_q;
    logic [N-1:0]     en_nx;
    logic [N-1:0]     pend_q;
    logic [N-1:0]     pend_nx;
    logic [IDX_W-1:0] low_idx;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_nx;
    logic [CNT_W-1:0] n_gain;
    logic [CNT_W-1:0] n_lose;
    logic             irq_q;
    logic             fiq_q;

    // Decode the access and qualify the write strobes.
    always_comb begin
        acc       = decode_ofs(bus_addr);
        idx_ok    = (bus_wdata < 32'(N));
        clear_all = bus_wr && (acc == ACC_CLRALL);
        set_en    = bus_wr && (acc == ACC_EN)  && idx_ok;
        clr_en    = bus_wr && (acc == ACC_DIS) && idx_ok;
    end

    pic_level_latch #(.N(N)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (irq_in[N-1:0]),
        .clear_all  (clear_all),
        .level_o    (level_q),
        .level_nx_o (level_nx)
    );

    pic_enable_regs #(.N(N), .IDX_W(IDX_W)) u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (set_en),
        .clr_en  (clr_en),
        .idx     (bus_wdata[IDX_W-1:0]),
        .en_o    (en_q),
        .en_nx_o (en_nx)
    );

    assign pend_q  = level_q & en_q;
    assign pend_nx = level_nx & en_nx;

    pic_lowest #(.N(N), .IDX_W(IDX_W)) u_lowest (
        .vec   (pend_q),
        .idx_o (low_idx)
    );

    // Count the lines that become pending and the ones that stop.
    always_comb begin
        n_gain = '0;
        n_lose = '0;
        for (int i = 0; i < N; i++) begin
            n_gain = n_gain + CNT_W'(pend_nx[i] & ~pend_q[i]);
            n_lose = n_lose + CNT_W'(pend_q[i] & ~pend_nx[i]);
        end
        count_nx = clear_all ? '0 : (count_q + n_gain - n_lose);
    end

    // Register the pending count and both request outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            irq_q   <= 1'b0;
            fiq_q   <= 1'b0;
        end else begin
            count_q <= count_nx;
            irq_q   <= |pend_nx;
            fiq_q   <= |(level_nx & FAST_MASK[N-1:0]);
        end
    end

    // Read mux: mapped registers only, zero otherwise.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (acc)
                ACC_COUNT: bus_rdata = 32'(count_q);
                ACC_LINE:  bus_rdata = 32'(low_idx);
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign irq_o = irq_q;
    assign fiq_o = fiq_q;

    p_count_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count_q) == $countones(pend_q));
    p_clear_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (count_q == '0) && $stable(en_q));
    p_lowest_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != '0) |-> (pend_q[low_idx] && ((pend_q & ((N'(1) << low_idx) - N'(1))) == '0)));
    p_irq_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (pend_q != '0));
    p_fiq_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o == ((level_q & FAST_MASK[N-1:0]) != '0));
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (count_q == '0) && !irq_o && !fiq_o);
endmodule

// File: tb/sim_level_irq_ctrl.sv
module sim_level_irq_ctrl;
    localparam logic [31:0] FMASK = 32'h0000_00F0;
    localparam int LIMIT = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        fiq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Behavioural reference state.
    bit [31:0] m_prev, m_lvl, m_en;
    bit        m_irq, m_fiq;

    level_irq_ctrl #(.N(32), .FAST_MASK(FMASK)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #5 clk = ~clk;

    function automatic int m_count();
        int c = 0;
        for (int i = 0; i < 32; i++) if (m_lvl[i] && m_en[i]) c++;
        return c;
    endfunction

    function automatic int m_lowest();
        for (int i = 0; i < 32; i++) if (m_lvl[i] && m_en[i]) return i;
        return 0;
    endfunction

    // Reference update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = 0; m_lvl = 0; m_en = 0; m_irq = 0; m_fiq = 0;
        end else begin
            bit clr;
            clr = bus_wr && bus_addr == 12'h008;
            if (bus_wr && bus_addr == 12'h010 && bus_wdata < 32) m_en[bus_wdata] = 1;
            if (bus_wr && bus_addr == 12'h00C && bus_wdata < 32) m_en[bus_wdata] = 0;
            for (int i = 0; i < 32; i++) begin
                if (clr) m_lvl[i] = 0;
                else if (irq_in[i] && !m_prev[i]) m_lvl[i] = 1;
                else if (!irq_in[i] && m_prev[i]) m_lvl[i] = 0;
            end
            m_prev = irq_in;
            m_irq = (m_lvl & m_en) != 0;
            m_fiq = (m_lvl & FMASK) != 0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] exp_rd;
            check("R8 irq_o", 32'(irq_o), 32'(m_irq));
            check("R9 fiq_o", 32'(fiq_o), 32'(m_fiq));
            exp_rd = 0;
            if (bus_rd && bus_addr == 12'h000) exp_rd = m_count();
            if (bus_rd && bus_addr == 12'h004) exp_rd = m_lowest();
            if (bus_rd && bus_addr == 12'h000)      check("R5 count", bus_rdata, exp_rd);
            else if (bus_rd && bus_addr == 12'h004) check("R6 line", bus_rdata, exp_rd);
            else                                    check("R10 other read", bus_rdata, exp_rd);
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(); bus_wr = 1; bus_addr = a; bus_wdata = d; bus_rd = 0;
        step(); bus_wr = 0;
    endtask

    task automatic rd_expect(input logic [11:0] a, input logic [31:0] exp, input string tag);
        step(); bus_rd = 1; bus_addr = a;
        @(negedge clk); #2;
        check(tag, bus_rdata, exp);
        bus_rd = 0;
    endtask

    task automatic set_in(input logic [31:0] v);
        step(); irq_in = v;
        step();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(LIMIT * 10);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        step();
        // R1: reset state
        check("R1 irq_o after reset", 32'(irq_o), 0);
        check("R1 fiq_o after reset", 32'(fiq_o), 0);
        rd_expect(12'h000, 0, "R1 count after reset");
        // R2 / R1: lines latch but enables are clear
        set_in(32'h0000_0009);
        rd_expect(12'h000, 0, "R1 enables clear after reset");
        // R3: enable by index, idempotent
        wr(12'h010, 3);
        rd_expect(12'h000, 1, "R3 enable line 3");
        wr(12'h010, 3);
        rd_expect(12'h000, 1, "R3 enable twice");
        check("R8 irq_o with pending", 32'(irq_o), 1);
        wr(12'h010, 0);
        rd_expect(12'h000, 2, "R5 two pending");
        rd_expect(12'h004, 0, "R6 lowest is 0");
        // R4: disable by index, idempotent
        wr(12'h00C, 0);
        rd_expect(12'h000, 1, "R4 disable line 0");
        rd_expect(12'h004, 3, "R6 lowest is 3");
        wr(12'h00C, 0);
        rd_expect(12'h000, 1, "R4 disable twice");
        // R10: out-of-range index and unmapped offsets
        set_in(32'h0000_0029);
        wr(12'h010, 37);
        rd_expect(12'h000, 1, "R10 index 37 ignored");
        wr(12'h014, 5);
        rd_expect(12'h000, 1, "R10 unmapped write");
        rd_expect(12'h014, 0, "R10 unmapped read");
        // R7: clear-all collides with a rising enabled line
        wr(12'h010, 7);
        step(); bus_wr = 1; bus_addr = 12'h008; irq_in = 32'h0000_00A9;
        step(); bus_wr = 0;
        rd_expect(12'h000, 0, "R7 count cleared");
        check("R7 irq_o after clear", 32'(irq_o), 0);
        set_in(32'h0000_00A1);
        set_in(32'h0000_00A9);
        rd_expect(12'h000, 1, "R7 enables kept, line 3 relatched");
        rd_expect(12'h004, 3, "R7 line 7 held high stays clear");
        // R9: fast mask
        check("R9 fiq low", 32'(fiq_o), 0);
        set_in(32'h0000_00B9);
        check("R9 fiq from line 4", 32'(fiq_o), 1);
        rd_expect(12'h000, 1, "R9 line 4 not in count");
        // Random mix of edges and writes.
        for (int k = 0; k < 4000; k++) begin
            int r;
            step();
            r = $urandom_range(0, 15);
            if (r < 6) irq_in = irq_in ^ (32'h1 << $urandom_range(0, 31));
            if (r == 6) irq_in = irq_in ^ $urandom;
            bus_wr = 0; bus_rd = 0;
            case ($urandom_range(0, 9))
                0: begin bus_wr = 1; bus_addr = 12'h010; bus_wdata = $urandom_range(0, 31); end
                1: begin bus_wr = 1; bus_addr = 12'h00C; bus_wdata = $urandom_range(0, 31); end
                2: if ($urandom_range(0, 7) == 0) begin bus_wr = 1; bus_addr = 12'h008; end
                3: begin bus_wr = 1; bus_addr = 12'h010; bus_wdata = $urandom_range(32, 300); end
                4: begin bus_wr = 1; bus_addr = 12'(4 * $urandom_range(5, 40)); bus_wdata = $urandom_range(0, 31); end
                5, 6: begin bus_rd = 1; bus_addr = 12'h000; end
                7: begin bus_rd = 1; bus_addr = 12'h004; end
                8: begin bus_rd = 1; bus_addr = 12'(4 * $urandom_range(2, 40)); end
                default: ;
            endcase
        end
        step(); bus_wr = 0; bus_rd = 0;
        step();
        done = 1;
        summary();
    end
endmodule